// File: doc/BRIEF.md
# Three-Phase Reset-Synchronous PWM Timer

The block drives three complementary PWM output pairs from a single shared up-counter. The counter advances once for each cycle in which the count-enable input `tick` is high. It returns to zero after it reaches the period value `period`, so one PWM period lasts `period+1` ticks. Each phase has its own compare value. A phase's normal-phase output is active while the count is above that compare value. Its counter-phase output is active for the rest of the period. A separate output changes level once per period, and a one-cycle trigger pulse marks each counter reset so that it can start an A/D conversion.

Software starts the block with a one-cycle start pulse, which also clears the counter. In continuous mode a stop pulse halts it. In one-shot mode the block runs one full period and then halts by itself. While the block is halted, every pair output sits at its programmed initial level. The asynchronous cutoff input overrides everything and forces every pair output to its inactive level at once. Compare values can be used directly or through a shadow register that is reloaded only at counter reset and at start. Event flags report the period match, each phase's compare match and counter overflow.

Top module: `tpwm_timer`

## Requirements
- R1: While running, the counter advances by one on each cycle with `tick` high and returns to 0 on the tick that finds it equal to `period` (m), so one period spans m+1 ticks.
- R2: For a phase with compare value n < m, the normal-phase output is at its active level for m−n ticks per period, namely while the count is greater than n.
- R3: The counter-phase output is at its active level for n+1 ticks per period. A compare value n ≥ m is clamped to m, so the normal-phase output stays inactive and the counter-phase output stays active for the whole period.
- R4: Each output has its own active-level bit (`act_n[i]`, `act_c[i]`), where 1 means active high and 0 means active low.
- R5: `pwm_tog` is 0 after reset and inverts exactly once per period, on the counter-reset tick.
- R6: A `start_set` pulse clears the counter and starts counting, and it wins over a stop in the same cycle. In continuous mode (`oneshot`=0) a `stop_req` pulse clears `running` at the next edge. In one-shot mode `stop_req` has no effect.
- R7: In one-shot mode (`oneshot`=1) the block halts by itself at the period match, after exactly m+1 ticks, and `running` drops at that edge.
- R8: Whenever `running` is 0, including after reset, `pwm_n` equals `init_n` and `pwm_c` equals `init_c`.
- R9: While `cutoff` is 1, without waiting for a clock edge, `pwm_n` equals `~act_n` and `pwm_c` equals `~act_c`.
- R10: `irq_per`, `irq_cmp[i]` and `irq_ovf` are one-cycle pulses in the cycle after a tick that finds, respectively, count == m, count == n_i, or the count at all ones. A compare value above m never matches.
- R11: With `buf_en`=1, compare values are taken from shadow copies that load only at start and at counter reset, so a mid-period write first takes effect in the next period. With `buf_en`=0 a write takes effect at once.
- R12: When `trig_en` is 1, `adc_trig` pulses for one cycle together with each `irq_per`. When `trig_en` is 0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable source, one tick per high cycle |
| start_set | input | 1 | One-cycle start pulse that clears the counter |
| stop_req | input | 1 | One-cycle stop pulse, used in continuous mode only |
| oneshot | input | 1 | 1 selects one-shot mode, 0 selects continuous mode |
| buf_en | input | 1 | 1 makes compare values pass through shadow registers |
| trig_en | input | 1 | Enables the A/D trigger pulse |
| cutoff | input | 1 | Asynchronous forced cutoff |
| period | input | CNT_W | Period value m |
| cmp | input | PHASES*CNT_W | Compare values, phase i in bits [i*CNT_W +: CNT_W] |
| act_n | input | PHASES | Active level of each normal-phase output |
| act_c | input | PHASES | Active level of each counter-phase output |
| init_n | input | PHASES | Level of each normal-phase output while halted |
| init_c | input | PHASES | Level of each counter-phase output while halted |
| pwm_n | output | PHASES | Normal-phase outputs |
| pwm_c | output | PHASES | Counter-phase outputs |
| pwm_tog | output | 1 | Output that inverts once per period |
| running | output | 1 | Counter is running |
| irq_per | output | 1 | Period-match pulse |
| irq_cmp | output | PHASES | Per-phase compare-match pulses |
| irq_ovf | output | 1 | Counter overflow pulse |
| adc_trig | output | 1 | A/D trigger pulse at counter reset |

## Verification
The duty function is measured as active-cycle counts over windows of whole periods. Three compare patterns are used: one with mid-range values and a value above the period, one with the extremes 0, m−1 and m, and one at the maximum period where the counter wraps. Each pattern separates the normal-phase and counter-phase widths from the clamp case. A run with `tick` high only on every other cycle separates counting by tick from counting by clock. Mixed active-low settings show whether the polarity is applied per output. A mid-period compare write is made with and without buffering: it tells immediate use apart from deferred use, because the output level in the very next cycle differs between the two.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

  // Per-phase output level settings, gathered from the flat top-level ports.
  typedef struct packed {
    logic act_n;
    logic act_c;
    logic init_n;
    logic init_c;
  } lvl_t;

  // Level of one output pin: cutoff first, then the halted level, then the PWM state.
  function automatic logic pin_drive(input logic act_lvl, input logic init_lvl,
                                     input logic on, input logic running,
                                     input logic cut);
    if (cut)      return ~act_lvl;
    if (!running) return init_lvl;
    return on ? act_lvl : ~act_lvl;
  endfunction

endpackage

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_set,
  input  logic          stop_req,
  input  logic          oneshot,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          adv,
  output logic          per_evt,
  output logic          ovf_evt,
  output logic          tog
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic halt_req;

  // Value after one tick: wrap on the period match, otherwise step by one.
  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  assign halt_req = stop_req && !oneshot;
  assign adv      = run && tick && !start_set && !halt_req;
  assign per_evt  = adv && (cnt == period);
  assign ovf_evt  = adv && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
      tog <= 1'b0;
    end else if (start_set) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (halt_req) begin
      run <= 1'b0;
    end else if (adv) begin
      cnt <= next_count(cnt, per_evt);
      if (per_evt) begin
        tog <= ~tog;
        if (oneshot) run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpwm_phase.sv
module tpwm_phase
  import tpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          buf_en,
  input  logic          adv,
  input  logic          run,
  input  logic          cutoff,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] cmp_in,
  input  lvl_t          lvl,
  output logic          out_n,
  output logic          out_c,
  output logic          match_evt
);
  logic [CW-1:0] shadow;
  logic [CW-1:0] n_used;
  logic [CW-1:0] n_clamped;
  logic          norm_on;

  // A compare value at or above the period is treated as the period.
  function automatic logic [CW-1:0] clamp_cmp(input logic [CW-1:0] n,
                                              input logic [CW-1:0] m);
    return (n >= m) ? m : n;
  endfunction

  // The normal phase is active in the part of the period above the compare value.
  function automatic logic normal_active(input logic [CW-1:0] c,
                                         input logic [CW-1:0] n);
    return c > n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shadow <= '0;
    else if (load) shadow <= cmp_in;
  end

  assign n_used    = buf_en ? shadow : cmp_in;
  assign n_clamped = clamp_cmp(n_used, period);
  assign norm_on   = normal_active(cnt, n_clamped);
  assign match_evt = adv && (cnt == n_used);

  assign out_n = pin_drive(lvl.act_n, lvl.init_n, norm_on,  run, cutoff);
  assign out_c = pin_drive(lvl.act_c, lvl.init_c, !norm_on, run, cutoff);
endmodule

// File: rtl/tpwm_timer.sv
module tpwm_timer
  import tpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PHASES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    start_set,
  input  logic                    stop_req,
  input  logic                    oneshot,
  input  logic                    buf_en,
  input  logic                    trig_en,
  input  logic                    cutoff,
  input  logic [CNT_W-1:0]        period,
  input  logic [PHASES*CNT_W-1:0] cmp,
  input  logic [PHASES-1:0]       act_n,
  input  logic [PHASES-1:0]       act_c,
  input  logic [PHASES-1:0]       init_n,
  input  logic [PHASES-1:0]       init_c,
  output logic [PHASES-1:0]       pwm_n,
  output logic [PHASES-1:0]       pwm_c,
  output logic                    pwm_tog,
  output logic                    running,
  output logic                    irq_per,
  output logic [PHASES-1:0]       irq_cmp,
  output logic                    irq_ovf,
  output logic                    adc_trig
);
  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic              adv;
  logic              per_evt;
  logic              ovf_evt;
  logic              tog;
  logic              shadow_load;
  logic [PHASES-1:0] match_vec;

  assign shadow_load = start_set || per_evt;

  tpwm_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_set(start_set),
    .stop_req(stop_req), .oneshot(oneshot), .period(period),
    .cnt(cnt), .run(run), .adv(adv), .per_evt(per_evt),
    .ovf_evt(ovf_evt), .tog(tog)
  );

  for (genvar i = 0; i < PHASES; i++) begin : g_ph
    lvl_t lvl;
    assign lvl = '{act_n: act_n[i], act_c: act_c[i],
                   init_n: init_n[i], init_c: init_c[i]};
    tpwm_phase #(.CW(CNT_W)) u_ph (
      .clk(clk), .rst_n(rst_n), .load(shadow_load), .buf_en(buf_en),
      .adv(adv), .run(run), .cutoff(cutoff), .cnt(cnt), .period(period),
      .cmp_in(cmp[i*CNT_W +: CNT_W]), .lvl(lvl),
      .out_n(pwm_n[i]), .out_c(pwm_c[i]), .match_evt(match_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_per  <= 1'b0;
      irq_cmp  <= '0;
      irq_ovf  <= 1'b0;
      adc_trig <= 1'b0;
    end else begin
      irq_per  <= per_evt;
      irq_cmp  <= match_vec;
      irq_ovf  <= ovf_evt;
      adc_trig <= per_evt && trig_en;
    end
  end

  assign pwm_tog = tog;
  assign running = run;
endmodule

// File: rtl/tpwm_timer_chk.sv
module tpwm_timer_chk #(
  parameter int CW = 8,
  parameter int PH = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_set,
  input logic          stop_req,
  input logic          oneshot,
  input logic          cutoff,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] period,
  input logic          run,
  input logic          adv,
  input logic          per_evt,
  input logic          pwm_tog,
  input logic [PH-1:0] pwm_n,
  input logic [PH-1:0] pwm_c,
  input logic [PH-1:0] act_n,
  input logic [PH-1:0] act_c,
  input logic [PH-1:0] init_n,
  input logic [PH-1:0] init_c,
  input logic          irq_per,
  input logic          irq_ovf,
  input logic          adc_trig
);
  localparam logic [CW-1:0] ALL_ONES = '1;

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> cnt == '0);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt != period) |=> cnt == $past(cnt) + 1'b1);

  a_r5_flip: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> pwm_tog != $past(pwm_tog));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !per_evt |=> $stable(pwm_tog));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !oneshot && !start_set) |=> !run);

  a_r7_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (per_evt && oneshot) |=> !run);

  a_r8_init: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cutoff) |-> (pwm_n == init_n && pwm_c == init_c));

  a_r9_cut: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff |-> (pwm_n == ~act_n && pwm_c == ~act_c));

  // R2 and R3: exactly one output of each pair is at its active level while running
  a_r3_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cutoff) |-> (((pwm_n ~^ act_n) ^ (pwm_c ~^ act_c)) == '1));

  a_r10_per: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> irq_per);

  a_r10_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> $past(cnt) == ALL_ONES);

  a_r12_trig: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> irq_per);
endmodule

bind tpwm_timer tpwm_timer_chk #(.CW(CNT_W), .PH(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_set(start_set), .stop_req(stop_req),
  .oneshot(oneshot), .cutoff(cutoff), .cnt(cnt), .period(period),
  .run(run), .adv(adv), .per_evt(per_evt), .pwm_tog(pwm_tog),
  .pwm_n(pwm_n), .pwm_c(pwm_c), .act_n(act_n), .act_c(act_c),
  .init_n(init_n), .init_c(init_c), .irq_per(irq_per),
  .irq_ovf(irq_ovf), .adc_trig(adc_trig)
);

// File: tb/tpwm_timer_bench.sv
module tpwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, tick, start_set, stop_req, oneshot, buf_en, trig_en, cutoff;
  logic [7:0]  period;
  logic [23:0] cmp;
  logic [2:0]  act_n, act_c, init_n, init_c;
  logic [2:0]  pwm_n, pwm_c, irq_cmp;
  logic        pwm_tog, running, irq_per, irq_ovf, adc_trig;
  logic        half = 1'b0;

  int total = 0;
  int fails = 0;
  int pushed = 0;
  int done = 0;

  typedef struct {
    int len;
    int na[3];
    int ca[3];
    int cm[3];
    int tog;
    int per;
    int ovf;
    int trig;
  } item_t;

  item_t q[$];

  tpwm_timer u_tpwm_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_set(start_set),
    .stop_req(stop_req), .oneshot(oneshot), .buf_en(buf_en),
    .trig_en(trig_en), .cutoff(cutoff), .period(period), .cmp(cmp),
    .act_n(act_n), .act_c(act_c), .init_n(init_n), .init_c(init_c),
    .pwm_n(pwm_n), .pwm_c(pwm_c), .pwm_tog(pwm_tog), .running(running),
    .irq_per(irq_per), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
    .adc_trig(adc_trig)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // tick source: always high, or high on every other cycle
  initial begin
    tick = 1'b1;
    forever begin
      @(negedge clk);
      tick = half ? ~tick : 1'b1;
    end
  end

  task automatic start_run();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
  endtask

  // Driver: computes duty widths and event counts from the period and compare values
  task automatic run_item(input int m, input int n0, input int n1, input int n2,
                          input int div, input int k);
    item_t it;
    int n[3];
    n[0] = n0; n[1] = n1; n[2] = n2;
    half = (div == 2);
    period = 8'(m);
    cmp = {8'(n2), 8'(n1), 8'(n0)};
    start_run();
    repeat (2 * (m + 1) * div) @(negedge clk);
    it.len = k * (m + 1) * div;
    for (int i = 0; i < 3; i++) begin
      it.na[i] = (n[i] < m) ? k * div * (m - n[i]) : 0;
      it.ca[i] = (n[i] < m) ? k * div * (n[i] + 1) : k * div * (m + 1);
      it.cm[i] = (n[i] <= m) ? k : 0;
    end
    it.tog  = k;
    it.per  = k;
    it.ovf  = (m == 255) ? k : 0;
    it.trig = trig_en ? k : 0;
    q.push_back(it);
    pushed++;
    while (done != pushed) @(negedge clk);
    half = 1'b0;
  endtask

  // Monitor: counts active cycles and pulses over the window of each item
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        item_t it;
        int na[3], ca[3], cm[3];
        int tg, pr, ov, tr;
        logic prev;
        it = q.pop_front();
        for (int i = 0; i < 3; i++) begin na[i] = 0; ca[i] = 0; cm[i] = 0; end
        tg = 0; pr = 0; ov = 0; tr = 0;
        prev = pwm_tog;
        repeat (it.len) begin
          @(negedge clk);
          for (int i = 0; i < 3; i++) begin
            if (pwm_n[i] == act_n[i]) na[i]++;
            if (pwm_c[i] == act_c[i]) ca[i]++;
            if (irq_cmp[i]) cm[i]++;
          end
          if (pwm_tog != prev) tg++;
          prev = pwm_tog;
          if (irq_per)  pr++;
          if (irq_ovf)  ov++;
          if (adc_trig) tr++;
        end
        for (int i = 0; i < 3; i++) begin
          chk("R2", $sformatf("normal-phase active ticks, phase %0d", i), na[i], it.na[i]);
          chk("R3", $sformatf("counter-phase active ticks, phase %0d", i), ca[i], it.ca[i]);
          chk("R10", $sformatf("compare pulses, phase %0d", i), cm[i], it.cm[i]);
        end
        chk("R5", "toggle changes", tg, it.tog);
        chk("R1", "period pulses", pr, it.per);
        chk("R10", "overflow pulses", ov, it.ovf);
        chk("R12", "trigger pulses", tr, it.trig);
        done++;
      end
    end
  end

  task automatic wait_per();
    int g = 0;
    do begin @(negedge clk); g++; end while (!irq_per && g < 1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; start_set = 1'b0; stop_req = 1'b0; oneshot = 1'b0;
    buf_en = 1'b0; trig_en = 1'b1; cutoff = 1'b0;
    period = 8'd9; cmp = {8'd12, 8'd5, 8'd2};
    act_n = 3'b111; act_c = 3'b111; init_n = 3'b010; init_c = 3'b101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset pwm_n", pwm_n, 3'b010);
    chk("R8", "reset pwm_c", pwm_c, 3'b101);
    chk("R6", "reset running", running, 0);
    chk("R5", "reset toggle", pwm_tog, 0);
    chk("R10", "reset irq_per", irq_per, 0);

    // mid-range compares, one above the period (R2, R3)
    run_item(9, 2, 5, 12, 1, 3);
    // half-rate tick, trigger disabled (R1, R12)
    trig_en = 1'b0;
    run_item(9, 2, 5, 12, 2, 2);
    // mixed active levels and extreme compares (R4)
    trig_en = 1'b1;
    act_n = 3'b010; act_c = 3'b100;
    run_item(9, 0, 8, 9, 1, 2);
    act_n = 3'b111; act_c = 3'b111;
    // full-range period, counter wraps through all ones (R10)
    run_item(255, 10, 100, 255, 1, 1);

    // R9 cutoff, asynchronous
    period = 8'd9; cmp = {8'd12, 8'd5, 8'd2};
    act_n = 3'b110; act_c = 3'b011;
    start_run();
    repeat (5) @(negedge clk);
    cutoff = 1'b1; #1;
    chk("R9", "cutoff pwm_n before edge", pwm_n, 3'b001);
    chk("R9", "cutoff pwm_c before edge", pwm_c, 3'b100);
    @(negedge clk);
    chk("R9", "cutoff pwm_n held", pwm_n, 3'b001);
    cutoff = 1'b0; #1;
    chk("R9", "running through cutoff", running, 1);
    act_n = 3'b111; act_c = 3'b111;

    // R6 continuous stop, R8 halted levels
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk("R6", "stopped after stop_req", running, 0);
    chk("R8", "stopped pwm_n", pwm_n, 3'b010);
    chk("R8", "stopped pwm_c", pwm_c, 3'b101);

    // R11 unbuffered write takes effect at once
    buf_en = 1'b0; cmp = {8'd12, 8'd5, 8'd2};
    start_run();
    wait_per();
    repeat (4) @(negedge clk);
    cmp[7:0] = 8'd6;
    @(negedge clk);
    chk("R11", "unbuffered new compare at count 5", pwm_n[0], 0);
    // R11 buffered write deferred to the next period
    buf_en = 1'b1; cmp[7:0] = 8'd2;
    start_run();
    wait_per();
    repeat (4) @(negedge clk);
    cmp[7:0] = 8'd6;
    @(negedge clk);
    chk("R11", "buffered old compare at count 5", pwm_n[0], 1);
    wait_per();
    repeat (4) @(negedge clk);
    chk("R11", "buffered new compare after reset at count 4", pwm_n[0], 0);

    // R7 one-shot length, R6 stop ignored in one-shot
    buf_en = 1'b0; oneshot = 1'b1; period = 8'd9;
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    start_run();
    n = 0;
    while (running && n < 50) begin
      n++;
      stop_req = (n == 3);
      @(negedge clk);
    end
    stop_req = 1'b0;
    chk("R7", "one-shot running samples", n, 10);
    chk("R8", "one-shot end pwm_n", pwm_n, 3'b010);
    chk("R8", "one-shot end pwm_c", pwm_c, 3'b101);
    oneshot = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule